// File: doc/BRIEF.md
# Accumulator ALU with Condition-Code Stage

This block is the arithmetic and logic stage of a small accumulator-based processor core. It takes an 8-bit primary operand (the accumulator, the index register or a value read from memory, as the core chooses) and an 8-bit memory operand. It forms one of five results: add with carry, plain add, bitwise AND, shift left or arithmetic shift right. The result is combinational. Alongside it the block gives the candidate next condition-code value and a mask that shows which flags the chosen operation owns.

The condition-code register is kept inside the block. It has five flags: half carry H, interrupt mask I, negative N, zero Z and carry C. Its carry flag feeds the add-with-carry path. The register takes the candidate value on a rising clock edge only when the update enable is high. Flags outside the operation's mask keep their old values. The interrupt mask is never written by any operation. Instruction fetch, addressing modes and memory access belong to the surrounding core.

Top module: `acc_alu`

## Requirements
- R1: With op_sel = 0 (add with carry), result = (opnd_a + opnd_m + C) mod 256. The new C is the carry out of bit 7. The new H is the carry out of bit 3, and the incoming C counts toward it.
- R2: With op_sel = 1 (add), result = (opnd_a + opnd_m) mod 256. The new C is the carry out of bit 7 and the new H is the carry out of bit 3. The stored C has no effect on the result.
- R3: With op_sel = 2 (AND), result = opnd_a & opnd_m. Only N and Z may change.
- R4: With op_sel = 3 (shift left), result = {opnd_a[6:0], 0} and the new C = opnd_a[7]. H is unchanged.
- R5: With op_sel = 4 (arithmetic shift right), result = {opnd_a[7], opnd_a[7:1]} and the new C = opnd_a[0]. H is unchanged.
- R6: Whenever N or Z is in the mask, the new N equals result bit 7 and the new Z is 1 exactly when the result is 0.
- R7: Flag vectors are packed as {H, I, N, Z, C} in bits 4 down to 0. flag_mask is 10111 for the two adds, 00110 for AND and 00111 for both shifts. In ccr_next, every flag outside the mask equals the stored flag, so I never changes.
- R8: On a rising edge with upd_en high, ccr_q takes ccr_next. With upd_en low, ccr_q holds its value.
- R9: While rst_n is low, ccr_q is 01000 (only I set).
- R10: For op_sel codes 5 to 7, result = opnd_a and flag_mask = 00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 3 | Operation code (0 add with carry, 1 add, 2 AND, 3 shift left, 4 shift right) |
| opnd_a | input | 8 | Primary operand (accumulator, index or memory value) |
| opnd_m | input | 8 | Memory operand for the adds and AND |
| upd_en | input | 1 | Write enable for the condition-code register |
| result | output | 8 | Operation result |
| ccr_next | output | 5 | Candidate condition-code value {H,I,N,Z,C} |
| flag_mask | output | 5 | Flags owned by the selected operation |
| ccr_q | output | 5 | Stored condition-code register {H,I,N,Z,C} |

## Verification
The hardest situation to reach is an add with carry where the incoming C is 1 and that carry alone causes the half carry or the overflow out of bit 7. For example, 0x0F + 0x00 with C set, or 0xFF + 0x00 with C set. C can only be set by an earlier carry-producing operation that was committed with upd_en high. The stimulus therefore first commits a shift left of a value with bit 7 set, or an overflowing add, and then issues the add with carry. It also interleaves cycles with upd_en low, so that a stale C or H must persist across operations that do not own those flags.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned NIB_W  = 4;
    localparam int unsigned FLAG_W = 5;

    typedef enum logic [2:0] {
        OP_ADC = 3'd0,
        OP_ADD = 3'd1,
        OP_AND = 3'd2,
        OP_SHL = 3'd3,
        OP_SHR = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic h;
        logic i;
        logic n;
        logic z;
        logic c;
    } ccr_t;

    localparam ccr_t CCR_RESET = '{h: 1'b0, i: 1'b1, n: 1'b0, z: 1'b0, c: 1'b0};

    localparam logic [FLAG_W-1:0] MASK_ADD   = 5'b10111;
    localparam logic [FLAG_W-1:0] MASK_LOGIC = 5'b00110;
    localparam logic [FLAG_W-1:0] MASK_SHIFT = 5'b00111;
    localparam logic [FLAG_W-1:0] MASK_NONE  = 5'b00000;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int unsigned W   = 8,
    parameter int unsigned NIB = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         half_c,
    output logic         carry
);
    logic [W:0]   wide;
    logic [NIB:0] low;

    always_comb begin
        wide   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        low    = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
        sum    = wide[W-1:0];
        carry  = wide[W];
        half_c = low[NIB];
    end
endmodule

// File: rtl/alu8_shift_logic.sv
module alu8_shift_logic #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_res,
    output logic [W-1:0] shl_res,
    output logic         shl_c,
    output logic [W-1:0] shr_res,
    output logic         shr_c
);
    always_comb begin
        and_res = a & b;
        shl_res = {a[W-2:0], 1'b0};
        shl_c   = a[W-1];
        shr_res = {a[W-1], a[W-1:1]};
        shr_c   = a[0];
    end
endmodule

// File: rtl/alu8_ccr_reg.sv
module alu8_ccr_reg
    import alu8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_en,
    input  ccr_t d,
    output ccr_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CCR_RESET;
        end else if (upd_en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import alu8_pkg::*;
#(
    parameter int unsigned W   = DATA_W,
    parameter int unsigned NIB = NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_sel,
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_m,
    input  logic              upd_en,
    output logic [W-1:0]      result,
    output logic [FLAG_W-1:0] ccr_next,
    output logic [FLAG_W-1:0] flag_mask,
    output logic [FLAG_W-1:0] ccr_q
);
    ccr_t         cur, cand, nxt;
    logic [W-1:0] add_sum, and_res, shl_res, shr_res;
    logic         add_h, add_c, shl_c, shr_c, use_cin;
    logic [FLAG_W-1:0] mask;

    assign use_cin = (op_sel == OP_ADC) ? cur.c : 1'b0;

    alu8_adder #(.W(W), .NIB(NIB)) u_add (
        .a(opnd_a), .b(opnd_m), .cin(use_cin),
        .sum(add_sum), .half_c(add_h), .carry(add_c)
    );

    alu8_shift_logic #(.W(W)) u_sl (
        .a(opnd_a), .b(opnd_m),
        .and_res(and_res), .shl_res(shl_res), .shl_c(shl_c),
        .shr_res(shr_res), .shr_c(shr_c)
    );

    always_comb begin
        result = opnd_a;
        mask   = MASK_NONE;
        cand   = cur;
        case (op_sel)
            OP_ADC, OP_ADD: begin
                result = add_sum;
                mask   = MASK_ADD;
                cand.h = add_h;
                cand.c = add_c;
            end
            OP_AND: begin
                result = and_res;
                mask   = MASK_LOGIC;
            end
            OP_SHL: begin
                result = shl_res;
                mask   = MASK_SHIFT;
                cand.c = shl_c;
            end
            OP_SHR: begin
                result = shr_res;
                mask   = MASK_SHIFT;
                cand.c = shr_c;
            end
            default: begin
                result = opnd_a;
                mask   = MASK_NONE;
            end
        endcase
        cand.n = result[W-1];
        cand.z = (result == '0);
        nxt    = (cand & mask) | (cur & ~mask);
    end

    alu8_ccr_reg u_ccr (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .d(nxt), .q(cur)
    );

    assign ccr_next  = nxt;
    assign flag_mask = mask;
    assign ccr_q     = cur;
endmodule

// File: rtl/alu8_checker.sv
module alu8_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   op_sel,
    input logic         upd_en,
    input logic [W-1:0] result,
    input logic [4:0]   ccr_next,
    input logic [4:0]   flag_mask,
    input logic [4:0]   ccr_q
);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(ccr_q));

    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (ccr_q == $past(ccr_next)));

    a_r7_i_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(ccr_q[3]));

    a_r7_unmasked_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((ccr_next & ~flag_mask) == (ccr_q & ~flag_mask)));

    a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flag_mask[1] |-> (ccr_next[1] == (result == '0)));

    a_r6_neg: assert property (@(posedge clk) disable iff (!rst_n)
        flag_mask[2] |-> (ccr_next[2] == result[W-1]));

    a_r3_logic_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd2) |-> (flag_mask == 5'b00110));

    a_r10_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 3'd4) |-> (flag_mask == 5'b00000));
endmodule

bind acc_alu alu8_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .upd_en(upd_en),
    .result(result), .ccr_next(ccr_next), .flag_mask(flag_mask), .ccr_q(ccr_q)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] opnd_a = 8'd0;
    logic [7:0] opnd_m = 8'd0;
    logic       upd_en = 1'b0;
    logic [7:0] result;
    logic [4:0] ccr_next, flag_mask, ccr_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [4:0] ref_ccr = 5'b01000;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu i_acc_alu (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
        .opnd_m(opnd_m), .upd_en(upd_en), .result(result),
        .ccr_next(ccr_next), .flag_mask(flag_mask), .ccr_q(ccr_q)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic apply(input int op, input int a, input int m, input bit en);
        int cin, s, lo, res, msk, h, n, z, c, nxt;
        string t;
        @(negedge clk);
        op_sel = op[2:0]; opnd_a = a[7:0]; opnd_m = m[7:0]; upd_en = en;
        #1;
        cin = (op == 0) ? int'(ref_ccr[0]) : 0;
        h = ref_ccr[4]; c = ref_ccr[0];
        case (op)
            0, 1: begin
                s = a + m + cin; lo = (a % 16) + (m % 16) + cin;
                res = s % 256; c = (s > 255); h = (lo > 15); msk = 'h17;
            end
            2: begin res = a & m; msk = 'h06; end
            3: begin res = (a * 2) % 256; c = (a >= 128); msk = 'h07; end
            4: begin res = (a / 2) + ((a >= 128) ? 128 : 0); c = a % 2; msk = 'h07; end
            default: begin res = a; msk = 0; end
        endcase
        n = (res >= 128); z = (res == 0);
        nxt = (h * 16 + int'(ref_ccr[3]) * 8 + n * 4 + z * 2 + c) & msk;
        nxt = nxt | (int'(ref_ccr) & ~msk & 'h1f);
        t = tag_of(op);
        check(t, "result", int'(result), res);
        check("R7", "flag_mask", int'(flag_mask), msk);
        check(t, "ccr_next", int'(ccr_next), nxt);
        check("R8", "ccr_q", int'(ccr_q), int'(ref_ccr));
        if (msk != 0) check("R6", "N/Z", int'(ccr_next[2:1]), n * 2 + z);
        @(posedge clk);
        if (en) ref_ccr = nxt[4:0];
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 2 + 2);
        check("R9", "reset ccr_q", int'(ccr_q), 'h08);
        @(negedge clk); rst_n = 1'b1;
        check("R9", "ccr_q after release", int'(ccr_q), 'h08);
        // R2 overflow to zero, with half carry
        apply(1, 'hff, 'h01, 1);
        // R1 carry in alone makes half carry
        apply(0, 'h0f, 'h00, 1);
        apply(3, 'h80, 0, 1);           // R4 sets C, result zero
        apply(0, 'hff, 'h00, 1);        // R1 carry in overflows
        apply(3, 'h81, 0, 1);
        apply(2, 'hf0, 'h0f, 1);        // R3 zero, H and C kept
        apply(1, 'h01, 'h01, 0);        // R8 not committed
        apply(2, 'h80, 'hff, 0);
        apply(4, 'h81, 0, 1);           // R5 sign kept, C from bit 0
        apply(4, 'h01, 0, 1);
        apply(5, 'h5a, 'h33, 1);        // R10
        apply(7, 'h00, 'hff, 1);
        apply(1, 'h08, 'h08, 1);        // R2 half carry only
        apply(0, 'h7f, 'h01, 1);
        for (int k = 0; k < 400; k++) begin
            apply(int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 255)), bit'($urandom_range(0, 1)));
        end
        apply(6, 0, 0, 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule